// File: doc/BRIEF.md
# Quad-phase fetch/execute pipeline sequencer

This block produces the instruction timing for a small core whose program and data memories sit on separate buses. It splits each instruction cycle into four clock periods of the incoming oscillator clock. In each period exactly one phase strobe is high, Q1 to Q4 in turn. A quarter-rate clock output marks the cycle rate.

The sequencer owns the program counter and overlaps work in two stages. In each cycle it fetches the next program word and executes the word fetched in the cycle before. A branch or call request from the decoder is taken at the end of Q4. The word fetched alongside it is then discarded and executed as a NOP, and the branch target is fetched in the next cycle. On a call, the return address is pushed onto a small circular return stack.

The decoder, the ALU and the data memory sit outside the block. They use the instruction register, the NOP flag and the data-memory strobes.

Top module: `qphase_seq`

## Requirements
- R1: After reset is released, `q_stb` is one-hot and cycles 0001 (Q1), 0010 (Q2), 0100 (Q3), 1000 (Q4), then back to Q1. The first clock edge after release gives Q1.
- R2: `clk_quarter` is high during Q1 and Q2 and low during Q3 and Q4, so it runs at one quarter of the clock rate.
- R3: The program counter advances at the edge that ends Q1. At that edge `pm_addr` takes the current counter value and holds it through the rest of the cycle, so successive cycles fetch successive addresses.
- R4: At the edge that ends Q4, `ir` captures `pm_rdata` for the word at `pm_addr`. It holds that word through the whole of the next cycle, which is the cycle that executes it.
- R5: When the executing word is not a NOP, `dm_rd_stb` is high during Q2 and `dm_wr_stb` is high during Q4. Neither is high in any other phase.
- R6: A branch request (`br_req`) sampled at the end of Q4 loads the counter with `br_target`. The next cycle then fetches the target and sets `ex_nop` for the discarded word.
- R7: While `ex_nop` is high, both data-memory strobes stay low, and any branch or call request is ignored.
- R8: A taken call (`br_req` and `br_call`) pushes `pm_addr`, the address that follows the call, onto the return stack. `stk_push` pulses high during the following Q1, with the pushed value on `stk_wdata`.
- R9: The return stack has 8 entries. `stk_ptr` wraps from 7 to 0, so a ninth push overwrites the oldest entry. One clock after a push, `stk_top` shows the most recently pushed value.
- R10: While reset is high: `q_stb`, `clk_quarter`, `pm_addr`, `ir`, the strobes, `stk_push`, `stk_wdata`, `stk_ptr` and `stk_top` are all zero. `ex_nop` is one, so the first cycle after reset only fetches. The program counter restarts from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_rdata | input | 14 | Program memory read data for `pm_addr` |
| br_req | input | 1 | Executing word changes the program counter |
| br_call | input | 1 | The branch is a call (push return address) |
| br_target | input | 13 | Branch or call target address |
| q_stb | output | 4 | One-hot phase strobes, bit 0 = Q1 |
| clk_quarter | output | 1 | Quarter-rate cycle clock |
| pm_addr | output | 13 | Program memory fetch address |
| ir | output | 14 | Instruction register (word being executed) |
| ex_nop | output | 1 | Executing word is a forced NOP |
| dm_rd_stb | output | 1 | Data-memory operand read strobe (Q2) |
| dm_wr_stb | output | 1 | Data-memory result write strobe (Q4) |
| stk_push | output | 1 | Return-stack push pulse |
| stk_wdata | output | 13 | Value pushed on the return stack |
| stk_ptr | output | 3 | Return-stack write pointer |
| stk_top | output | 13 | Most recently pushed return address |

## Verification
The bench builds the block with its default parameters: a 13-bit counter, 14-bit words and an 8-entry stack. Its request schedule takes about two dozen calls, so the stack pointer wraps several times and overwrite of the oldest entry is exercised. Requests that arrive in the cycle right after a taken branch fall on the forced NOP, which checks that they are ignored. A reset part-way through the run checks the return to the initial state while stack contents from before the reset are still in memory.

// File: rtl/qseq_pkg.sv
`timescale 1ns/1ps
package qseq_pkg;
  localparam int NUM_PHASES = 4;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  // Phase that follows a given phase in the instruction cycle.
  function automatic phase_e next_phase(input phase_e cur);
    return phase_e'(cur + 2'd1);
  endfunction
endpackage

// File: rtl/qseq_phase.sv
`timescale 1ns/1ps
module qseq_phase
  import qseq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  output logic [NUM_PHASES-1:0] q_stb,
  output logic                  clk_quarter
);
  phase_e ph;
  phase_e ph_nxt;
  logic [NUM_PHASES-1:0] q_nxt;

  assign ph_nxt = next_phase(ph);

  // One-hot decode of the upcoming phase.
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_dec
    assign q_nxt[g] = (ph_nxt == phase_e'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph          <= PH_Q4;
      q_stb       <= '0;
      clk_quarter <= 1'b0;
    end else begin
      ph          <= ph_nxt;
      q_stb       <= q_nxt;
      clk_quarter <= (ph_nxt == PH_Q1) || (ph_nxt == PH_Q2);
    end
  end
endmodule

// File: rtl/qseq_fetch.sv
`timescale 1ns/1ps
module qseq_fetch
  import qseq_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int INSN_W = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PHASES-1:0] q_stb,
  input  logic [INSN_W-1:0]     pm_rdata,
  input  logic                  br_req,
  input  logic                  br_call,
  input  logic [PC_W-1:0]       br_target,
  output logic [PC_W-1:0]       pm_addr,
  output logic [INSN_W-1:0]     ir,
  output logic                  ex_nop,
  output logic                  dm_rd_stb,
  output logic                  dm_wr_stb,
  output logic                  take_call,
  output logic [PC_W-1:0]       ret_addr
);
  logic [PC_W-1:0] pc;
  logic            take;

  // A request from a forced NOP is ignored.
  assign take      = q_stb[PH_Q4] && br_req && !ex_nop;
  assign take_call = take && br_call;
  assign ret_addr  = pm_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      pm_addr   <= '0;
      ir        <= '0;
      ex_nop    <= 1'b1;
      dm_rd_stb <= 1'b0;
      dm_wr_stb <= 1'b0;
    end else begin
      dm_rd_stb <= q_stb[PH_Q1] && !ex_nop;
      dm_wr_stb <= q_stb[PH_Q3] && !ex_nop;
      if (q_stb[PH_Q1]) begin
        pm_addr <= pc;
        pc      <= pc + 1'b1;
      end
      if (q_stb[PH_Q4]) begin
        ir     <= pm_rdata;
        ex_nop <= take;
        if (take) pc <= br_target;
      end
    end
  end
endmodule

// File: rtl/qseq_stack.sv
`timescale 1ns/1ps
module qseq_stack #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 13,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  output logic              stk_push,
  output logic [DATA_W-1:0] stk_wdata,
  output logic [PTR_W-1:0]  stk_ptr,
  output logic [DATA_W-1:0] stk_top
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr_nxt;
  logic [PTR_W-1:0]  top_idx;

  assign ptr_nxt = (stk_ptr == LAST) ? '0 : stk_ptr + 1'b1;
  assign top_idx = (stk_ptr == '0) ? LAST : stk_ptr - 1'b1;

  // Storage without reset so it maps onto a RAM.
  always_ff @(posedge clk) begin
    if (push_en) mem[stk_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stk_ptr   <= '0;
      stk_push  <= 1'b0;
      stk_wdata <= '0;
      stk_top   <= '0;
    end else begin
      stk_push <= push_en;
      stk_top  <= mem[top_idx];
      if (push_en) begin
        stk_wdata <= push_data;
        stk_ptr   <= ptr_nxt;
      end
    end
  end
endmodule

// File: rtl/qphase_seq.sv
`timescale 1ns/1ps
module qphase_seq
  import qseq_pkg::*;
#(
  parameter int PC_W      = 13,
  parameter int INSN_W    = 14,
  parameter int STK_DEPTH = 8,
  localparam int SP_W     = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [INSN_W-1:0]     pm_rdata,
  input  logic                  br_req,
  input  logic                  br_call,
  input  logic [PC_W-1:0]       br_target,
  output logic [NUM_PHASES-1:0] q_stb,
  output logic                  clk_quarter,
  output logic [PC_W-1:0]       pm_addr,
  output logic [INSN_W-1:0]     ir,
  output logic                  ex_nop,
  output logic                  dm_rd_stb,
  output logic                  dm_wr_stb,
  output logic                  stk_push,
  output logic [PC_W-1:0]       stk_wdata,
  output logic [SP_W-1:0]       stk_ptr,
  output logic [PC_W-1:0]       stk_top
);
  logic            take_call;
  logic [PC_W-1:0] ret_addr;

  qseq_phase i_phase (
    .clk         (clk),
    .rst         (rst),
    .q_stb       (q_stb),
    .clk_quarter (clk_quarter)
  );

  qseq_fetch #(.PC_W(PC_W), .INSN_W(INSN_W)) i_fetch (
    .clk       (clk),
    .rst       (rst),
    .q_stb     (q_stb),
    .pm_rdata  (pm_rdata),
    .br_req    (br_req),
    .br_call   (br_call),
    .br_target (br_target),
    .pm_addr   (pm_addr),
    .ir        (ir),
    .ex_nop    (ex_nop),
    .dm_rd_stb (dm_rd_stb),
    .dm_wr_stb (dm_wr_stb),
    .take_call (take_call),
    .ret_addr  (ret_addr)
  );

  qseq_stack #(.DEPTH(STK_DEPTH), .DATA_W(PC_W)) i_stack (
    .clk       (clk),
    .rst       (rst),
    .push_en   (take_call),
    .push_data (ret_addr),
    .stk_push  (stk_push),
    .stk_wdata (stk_wdata),
    .stk_ptr   (stk_ptr),
    .stk_top   (stk_top)
  );
endmodule

// File: rtl/qphase_seq_chk.sv
`timescale 1ns/1ps
module qphase_seq_chk #(
  parameter int PC_W      = 13,
  parameter int INSN_W    = 14,
  parameter int STK_DEPTH = 8,
  localparam int SP_W     = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [INSN_W-1:0] pm_rdata,
  input logic              br_req,
  input logic              br_call,
  input logic [PC_W-1:0]   br_target,
  input logic [3:0]        q_stb,
  input logic              clk_quarter,
  input logic [PC_W-1:0]   pm_addr,
  input logic [INSN_W-1:0] ir,
  input logic              ex_nop,
  input logic              dm_rd_stb,
  input logic              dm_wr_stb,
  input logic              stk_push,
  input logic [PC_W-1:0]   stk_wdata,
  input logic [SP_W-1:0]   stk_ptr,
  input logic [PC_W-1:0]   stk_top
);
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (q_stb == 4'b1000) |=> (q_stb == 4'b0001)); // R1
  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (q_stb != 4'b0000) |-> $onehot0(q_stb)); // R1
  AST_QUARTER_HI: assert property (@(posedge clk) disable iff (rst)
    (q_stb[0] || q_stb[1]) |-> clk_quarter); // R2
  AST_QUARTER_LO: assert property (@(posedge clk) disable iff (rst)
    (q_stb[2] || q_stb[3]) |-> !clk_quarter); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(q_stb[0])) |-> $stable(pm_addr)); // R3
  AST_RD_IN_Q2: assert property (@(posedge clk) disable iff (rst)
    dm_rd_stb |-> q_stb[1]); // R5
  AST_WR_IN_Q4: assert property (@(posedge clk) disable iff (rst)
    dm_wr_stb |-> q_stb[3]); // R5
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    ex_nop |-> (!dm_wr_stb && !dm_rd_stb)); // R7
  AST_PUSH_FLUSHES: assert property (@(posedge clk) disable iff (rst)
    stk_push |-> (ex_nop && q_stb[0])); // R8
endmodule

bind qphase_seq qphase_seq_chk #(
  .PC_W(PC_W), .INSN_W(INSN_W), .STK_DEPTH(STK_DEPTH)
) i_chk (.*);

// File: tb/test_qphase_seq.sv
`timescale 1ns/1ps
module test_qphase_seq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] pm_rdata;
  logic        br_req = 1'b0;
  logic        br_call = 1'b0;
  logic [12:0] br_target = '0;
  logic [3:0]  q_stb;
  logic        clk_quarter;
  logic [12:0] pm_addr;
  logic [13:0] ir;
  logic        ex_nop;
  logic        dm_rd_stb;
  logic        dm_wr_stb;
  logic        stk_push;
  logic [12:0] stk_wdata;
  logic [2:0]  stk_ptr;
  logic [12:0] stk_top;

  int n_vec = 0;
  int n_bad = 0;
  bit running = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [13:0] pm_word(input logic [12:0] a);
    return {a, 1'b1} ^ 14'h1A5C;
  endfunction

  assign pm_rdata = pm_word(pm_addr);

  qphase_seq i_qphase_seq (
    .clk(clk), .rst(rst), .pm_rdata(pm_rdata), .br_req(br_req),
    .br_call(br_call), .br_target(br_target), .q_stb(q_stb),
    .clk_quarter(clk_quarter), .pm_addr(pm_addr), .ir(ir), .ex_nop(ex_nop),
    .dm_rd_stb(dm_rd_stb), .dm_wr_stb(dm_wr_stb), .stk_push(stk_push),
    .stk_wdata(stk_wdata), .stk_ptr(stk_ptr), .stk_top(stk_top)
  );

  // Behavioural reference model, updated on every rising edge.
  int          m_q, m_ptr, m_topv;
  logic        m_cko, m_nop, m_rd, m_wr, m_push;
  logic [12:0] m_pc, m_addr, m_wdata, m_top;
  logic [13:0] m_ir;
  logic [12:0] m_stk [8];
  bit          m_seen [8];

  initial for (int k = 0; k < 8; k++) m_seen[k] = 1'b0;

  always @(posedge clk) begin
    int  old_q, ti;
    bit  take;
    if (rst) begin
      m_q = 0; m_cko = 0; m_pc = '0; m_addr = '0; m_ir = '0; m_nop = 1;
      m_rd = 0; m_wr = 0; m_push = 0; m_wdata = '0; m_ptr = 0;
      m_top = '0; m_topv = 1;
    end else begin
      ti = (m_ptr + 7) % 8;
      m_topv = m_seen[ti];
      m_top = m_stk[ti];
      old_q = m_q;
      take = (old_q == 8) && br_req && !m_nop;
      m_rd = (old_q == 1) && !m_nop;
      m_wr = (old_q == 4) && !m_nop;
      m_cko = (old_q == 0) || (old_q == 8) || (old_q == 1);
      m_q = (old_q == 0 || old_q == 8) ? 1 : old_q * 2;
      m_push = 0;
      if (old_q == 1) begin
        m_addr = m_pc;
        m_pc = m_pc + 13'd1;
      end
      if (old_q == 8) begin
        m_ir = pm_word(m_addr);
        m_nop = take;
        if (take) m_pc = br_target;
        if (take && br_call) begin
          m_stk[m_ptr] = m_addr;
          m_seen[m_ptr] = 1'b1;
          m_wdata = m_addr;
          m_push = 1;
          m_ptr = (m_ptr + 1) % 8;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // Compare every output on the falling edge, away from the active edge.
  always @(negedge clk) if (running) begin
    chk("R1 q_stb", 32'(q_stb), 32'(m_q));
    chk("R2 clk_quarter", 32'(clk_quarter), 32'(m_cko));
    chk("R3 pm_addr", 32'(pm_addr), 32'(m_addr));
    chk("R4 ir", 32'(ir), 32'(m_ir));
    chk("R6 ex_nop", 32'(ex_nop), 32'(m_nop));
    chk("R5 dm_rd_stb", 32'(dm_rd_stb), 32'(m_rd));
    chk("R5 dm_wr_stb", 32'(dm_wr_stb), 32'(m_wr));
    chk("R8 stk_push", 32'(stk_push), 32'(m_push));
    chk("R8 stk_wdata", 32'(stk_wdata), 32'(m_wdata));
    chk("R9 stk_ptr", 32'(stk_ptr), 32'(m_ptr));
    if (m_topv != 0) chk("R9 stk_top", 32'(stk_top), 32'(m_top));
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (q_stb != 4'b0001);
      // R6 jumps, R8 calls; a request right after a taken one hits a NOP (R7)
      br_req    = (i % 5 == 0) || (i % 5 == 2) || (i % 5 == 3);
      br_call   = (i % 5 != 2);
      br_target = 13'((i * 53 + 7) % 8192);
    end
    @(negedge clk);
    br_req = 1'b0;
  endtask

  task automatic check_reset_state();
    // R10: every output at its reset value while reset is held
    chk("R10 q_stb", 32'(q_stb), 32'd0);
    chk("R10 pm_addr", 32'(pm_addr), 32'd0);
    chk("R10 ir", 32'(ir), 32'd0);
    chk("R10 ex_nop", 32'(ex_nop), 32'd1);
    chk("R10 strobes", 32'({dm_rd_stb, dm_wr_stb, stk_push, clk_quarter}), 32'd0);
    chk("R10 stk_ptr", 32'(stk_ptr), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    running = 1'b1;
    check_reset_state();
    rst = 1'b0;
    run_cycles(120);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    run_cycles(20);
    repeat (8) @(negedge clk);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end
endmodule